// File: doc/BRIEF.md
# Predicated Vector Floating-Point Exponent Extraction Unit

This unit takes a packed vector of IEEE-754 values and, in every lane, returns the signed integer base-2 exponent of that lane's magnitude. The result is a two's-complement integer as wide as the input lane. Normal values give their unbiased exponent. Subnormal values give the exponent they would have once normalised. Infinities, zeros and NaNs map to fixed saturated codes. The sign of the input never affects the result.

A 2-bit size select picks lanes of 16, 32 or 64 bits. A byte-granular predicate marks which lanes are written. In merging mode, inactive lanes keep the old destination value; in zeroing mode, they are cleared. The result, together with a flag that reports an illegal size code, is captured in one register stage and qualified by a valid signal one cycle after the request. The vector length is a parameter, 128 bits by default.

Top module: `vec_logb_unit`

## Requirements
- R1: The size select sets the lane width: 01 gives 16 bits, 10 gives 32 bits and 11 gives 64 bits. Lane i occupies bits [i*W +: W] of every vector, and each result is written to the lane at the same position.
- R2: For a normal input (exponent field neither all zeros nor all ones) the result is exponent field minus bias, with bias 15, 127 or 1023 for 16, 32 or 64 bits. The result is a two's-complement value in the lane width, and the sign bit is ignored.
- R3: For a subnormal input (exponent field zero, fraction nonzero) the result is (1 - bias) - (number of leading zeros of the fraction field + 1).
- R4: An infinity of either sign gives 2^(W-1)-1.
- R5: A zero of either sign, or any NaN (quiet or signalling), gives -2^(W-1).
- R6: A lane is active when the predicate bit of its lowest-numbered byte (bit i*W/8) is 1. The other predicate bits of the lane have no effect.
- R7: With mode 0 (merging), an inactive lane returns the old destination contents of that lane.
- R8: With mode 1 (zeroing), an inactive lane returns zero.
- R9: Size select 00 sets the illegal-size flag, and the result equals the old destination vector unchanged. A legal size clears the flag.
- R10: A request with in_valid high produces out_valid high on the next cycle, with the new result and flag. While in_valid is low, out_valid is low and the result and flag hold their values.
- R11: After reset, out_valid, the illegal-size flag and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| size_sel | input | 2 | Lane size code (01/10/11 legal, 00 illegal) |
| zero_mode | input | 1 | 1 = zeroing, 0 = merging for inactive lanes |
| src_vec | input | VLEN | Floating-point source lanes |
| old_dst | input | VLEN | Prior destination contents |
| pred | input | VLEN/8 | One predicate bit per byte |
| out_valid | output | 1 | Result qualifier |
| result | output | VLEN | Integer exponent lanes |
| bad_size | output | 1 | Illegal size code seen on the last request |

## Verification
The bench sweeps each lane width in both predication modes. At every width the inputs include every leading-one position of a subnormal fraction, which separates an off-by-one leading-zero count from a correct one. They also include the smallest, the largest and spread normal exponent fields, which expose bias and sign-extension faults. Both zeros, both infinities, and quiet and signalling NaNs with several payloads are applied, so that the saturated codes cannot be confused. Each vector is applied under all-active, random and first-byte-cleared predicates, which shows whether a lane is gated by its lowest byte only. Illegal size, hold-while-idle and the all-inactive case are applied separately.

// File: rtl/vlogb_pkg.sv
package vlogb_pkg;
  typedef enum logic [1:0] {
    SZ_BAD  = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } lane_size_e;

  localparam int EXPW_HALF = 5;
  localparam int EXPW_WORD = 8;
  localparam int EXPW_DBL  = 11;
endpackage

// File: rtl/vlogb_lane.sv
module vlogb_lane #(
  parameter int EW   = 16,
  parameter int EXPW = 5
) (
  input  logic [EW-1:0] operand,
  output logic [EW-1:0] logb
);
  localparam int FRACW = EW - 1 - EXPW;
  localparam int BIAS  = (1 << (EXPW - 1)) - 1;
  localparam logic [EW-1:0] POS_SAT = {1'b0, {(EW-1){1'b1}}};
  localparam logic [EW-1:0] NEG_SAT = {1'b1, {(EW-1){1'b0}}};

  logic [EXPW-1:0]  exp_fld;
  logic [FRACW-1:0] frac_fld;
  logic             unused_sign;
  int               lead;
  logic             seen;

  assign exp_fld     = operand[EW-2 -: EXPW];
  assign frac_fld    = operand[FRACW-1:0];
  assign unused_sign = operand[EW-1];

  // leading-zero count of the fraction field
  always_comb begin
    lead = 0;
    seen = 1'b0;
    for (int i = FRACW - 1; i >= 0; i--) begin
      if (!seen) begin
        if (frac_fld[i]) seen = 1'b1;
        else             lead = lead + 1;
      end
    end
  end

  always_comb begin
    if (&exp_fld) begin
      logb = (frac_fld == '0) ? POS_SAT : NEG_SAT;
    end else if (exp_fld == '0) begin
      if (frac_fld == '0) logb = NEG_SAT;
      else                logb = EW'((1 - BIAS) - (lead + 1));
    end else begin
      logb = EW'(int'(exp_fld) - BIAS);
    end
  end
endmodule

// File: rtl/vlogb_bank.sv
module vlogb_bank #(
  parameter int VLEN = 128,
  parameter int EW   = 16,
  parameter int EXPW = 5
) (
  input  logic [VLEN-1:0]   src_vec,
  input  logic [VLEN-1:0]   old_dst,
  input  logic [VLEN/8-1:0] pred,
  input  logic              zero_mode,
  output logic [VLEN-1:0]   bank_res
);
  localparam int NLANE = VLEN / EW;
  localparam int BPL   = EW / 8;

  logic [NLANE-1:0] lane_act;
  logic             any_act;
  logic [VLEN-1:0]  operand;
  logic             unused_pred;

  assign unused_pred = ^pred;

  for (genvar i = 0; i < NLANE; i++) begin : g_act
    assign lane_act[i] = pred[i*BPL];
  end

  assign any_act = |lane_act;
  assign operand = any_act ? src_vec : '0;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [EW-1:0] lane_lg;
    vlogb_lane #(.EW(EW), .EXPW(EXPW)) u_lane (
      .operand (operand[i*EW +: EW]),
      .logb    (lane_lg)
    );
    always_comb begin
      if (lane_act[i])    bank_res[i*EW +: EW] = lane_lg;
      else if (zero_mode) bank_res[i*EW +: EW] = '0;
      else                bank_res[i*EW +: EW] = old_dst[i*EW +: EW];
    end
  end
endmodule

// File: rtl/vec_logb_unit.sv
module vec_logb_unit
  import vlogb_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        size_sel,
  input  logic              zero_mode,
  input  logic [VLEN-1:0]   src_vec,
  input  logic [VLEN-1:0]   old_dst,
  input  logic [VLEN/8-1:0] pred,
  output logic              out_valid,
  output logic [VLEN-1:0]   result,
  output logic              bad_size
);
  localparam int PW     = VLEN / 8;
  localparam int NHALF  = VLEN / 16;

  logic [VLEN-1:0] res_half, res_word, res_dbl, res_sel;
  logic [VLEN-1:0] res_d, res_q;
  logic            bad_d, bad_q, vld_d, vld_q;
  lane_size_e      size_e;

  assign size_e = lane_size_e'(size_sel);

  vlogb_bank #(.VLEN(VLEN), .EW(16), .EXPW(EXPW_HALF)) u_bank_half (
    .src_vec(src_vec), .old_dst(old_dst), .pred(pred),
    .zero_mode(zero_mode), .bank_res(res_half));
  vlogb_bank #(.VLEN(VLEN), .EW(32), .EXPW(EXPW_WORD)) u_bank_word (
    .src_vec(src_vec), .old_dst(old_dst), .pred(pred),
    .zero_mode(zero_mode), .bank_res(res_word));
  vlogb_bank #(.VLEN(VLEN), .EW(64), .EXPW(EXPW_DBL)) u_bank_dbl (
    .src_vec(src_vec), .old_dst(old_dst), .pred(pred),
    .zero_mode(zero_mode), .bank_res(res_dbl));

  always_comb begin
    case (size_e)
      SZ_HALF: res_sel = res_half;
      SZ_WORD: res_sel = res_word;
      SZ_DBL:  res_sel = res_dbl;
      default: res_sel = old_dst;
    endcase
  end

  // next state
  always_comb begin
    res_d = res_q;
    bad_d = bad_q;
    vld_d = in_valid;
    if (in_valid) begin
      res_d = res_sel;
      bad_d = (size_e == SZ_BAD);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      bad_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      bad_q <= bad_d;
      vld_q <= vld_d;
    end
  end

  assign result    = res_q;
  assign bad_size  = bad_q;
  assign out_valid = vld_q;

  // assertions
  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(bad_size)));

  assert_illegal_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == 2'b00) |=> (bad_size && result == $past(old_dst)));

  assert_half_inf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == 2'b01 && pred[0] && src_vec[14:0] == 15'h7C00)
      |=> result[15:0] == 16'h7FFF);

  for (genvar i = 0; i < NHALF; i++) begin : g_chk
    assert_zeroing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_sel == 2'b01 && zero_mode && !pred[2*i])
        |=> result[16*i +: 16] == 16'h0000);
    assert_merging_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_sel == 2'b01 && !zero_mode && !pred[2*i])
        |=> result[16*i +: 16] == $past(old_dst[16*i +: 16]));
  end

  logic unused_pw;
  assign unused_pw = (PW == 0);
endmodule

// File: tb/test_vec_logb_unit.sv
module test_vec_logb_unit;
  localparam int VLEN = 128;
  localparam int PW   = VLEN / 8;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [1:0]      size_sel;
  logic            zero_mode;
  logic [VLEN-1:0] src_vec, old_dst;
  logic [PW-1:0]   pred;
  logic            out_valid, bad_size;
  logic [VLEN-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  vec_logb_unit #(.VLEN(VLEN)) i_vec_logb_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
    .zero_mode(zero_mode), .src_vec(src_vec), .old_dst(old_dst), .pred(pred),
    .out_valid(out_valid), .result(result), .bad_size(bad_size));

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int expw(input int w);
    return (w == 16) ? 5 : (w == 32) ? 8 : 11;
  endfunction

  function automatic logic [63:0] wmask(input int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 1);
  endfunction

  function automatic logic [63:0] model(input logic [63:0] v, input int w, output string req);
    int ew, fw, bias, p;
    longint e, r, emax;
    logic [63:0] f;
    ew = expw(w); fw = w - 1 - ew; bias = (1 << (ew - 1)) - 1;
    emax = (longint'(1) << ew) - 1;
    e = longint'((v >> fw) & ((64'd1 << ew) - 1));
    f = v & ((64'd1 << fw) - 1);
    if (e == emax) begin
      if (f == 0) begin r = (longint'(1) << (w - 1)) - 1; req = "R4"; end
      else        begin r = -(longint'(1) << (w - 1));    req = "R5"; end
    end else if (e == 0) begin
      if (f == 0) begin r = -(longint'(1) << (w - 1)); req = "R5"; end
      else begin
        p = 0;
        for (int b = 0; b < fw; b++) if (f[b]) p = b;
        r = (1 - bias) - (fw - p);
        req = "R3";
      end
    end else begin
      r = e - bias; req = "R2";
    end
    return 64'(r) & wmask(w);
  endfunction

  function automatic logic [63:0] gen(input int k, input int w);
    int ew, fw, j;
    longint emax;
    logic [63:0] fm, fr, ex, sg, rnd;
    ew = expw(w); fw = w - 1 - ew;
    emax = (longint'(1) << ew) - 1;
    fm = (64'd1 << fw) - 1;
    rnd = {$urandom, $urandom};
    sg = 0; ex = 0; fr = 0;
    if (k < 8) begin
      case (k)
        0: begin end
        1: sg = 1;
        2: ex = 64'(emax);
        3: begin ex = 64'(emax); sg = 1; end
        4: begin ex = 64'(emax); fr = 64'd1 << (fw - 1); end
        5: begin ex = 64'(emax); fr = 1; end
        6: begin ex = 64'(emax); fr = (64'd1 << (fw - 1)) | 3; sg = 1; end
        default: begin ex = 64'(emax); fr = rnd & fm; fr[fw-1] = 1'b0; fr[0] = 1'b1; end
      endcase
    end else if (k < 8 + fw) begin
      j = k - 8;
      fr = (64'd1 << j) | (rnd & ((64'd1 << j) - 1));
      sg = 64'(k & 1);
    end else begin
      j = k - 8 - fw;
      if (j == 0)      ex = 1;
      else if (j == 1) ex = 64'(emax - 1);
      else             ex = 64'(1 + ((longint'(j) * 97) % (emax - 1)));
      fr = rnd & fm;
      sg = 64'(j & 1);
    end
    return ((sg << (w - 1)) | (ex << fw) | (fr & fm)) & wmask(w);
  endfunction

  task automatic apply(input logic [1:0] sz, input logic zm, input logic [VLEN-1:0] s,
                       input logic [VLEN-1:0] o, input logic [PW-1:0] p);
    @(negedge clk);
    size_sel = sz; zero_mode = zm; src_vec = s; old_dst = o; pred = p; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check("R10 out_valid after request", 64'(out_valid), 64'd1);
  endtask

  task automatic check_vec(input int w, input logic zm, input logic [VLEN-1:0] s,
                           input logic [VLEN-1:0] o, input logic [PW-1:0] p);
    int nl;
    bit any;
    string req;
    logic [63:0] lane, exp;
    nl = VLEN / w;
    any = 0;
    for (int l = 0; l < nl; l++) if (p[l*(w/8)]) any = 1;
    for (int l = 0; l < nl; l++) begin
      lane = 64'((result >> (l*w))) & wmask(w);
      if (p[l*(w/8)]) exp = model(64'((s >> (l*w))) & wmask(w), w, req);
      else if (zm) begin exp = 0; req = "R8"; end
      else begin exp = 64'((o >> (l*w))) & wmask(w); req = "R7"; end
      check($sformatf("R1/%s/R6 w=%0d lane=%0d zm=%0d", req, w, l, zm), lane, exp);
    end
    check("R9 flag clear on legal size", 64'(bad_size), 64'd0);
    if (!any) check("R7 all inactive", 64'(result == (zm ? '0 : o)), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [VLEN-1:0] s, o;
    logic [PW-1:0] p;
    int w, nl, items, fw;
    logic [1:0] sz;
    rst_n = 0; in_valid = 0; size_sel = 0; zero_mode = 0;
    src_vec = '0; old_dst = '0; pred = '0;
    repeat (3) @(negedge clk);
    check("R11 reset out_valid", 64'(out_valid), 64'd0);
    check("R11 reset bad_size", 64'(bad_size), 64'd0);
    check("R11 reset result", 64'(result == '0), 64'd1);
    rst_n = 1;

    for (int wi = 0; wi < 3; wi++) begin
      w = 16 << wi; sz = 2'(wi + 1); nl = VLEN / w;
      fw = w - 1 - expw(w);
      items = 8 + fw + 64;
      for (int zm = 0; zm < 2; zm++) begin
        for (int base = 0; base < items; base += nl) begin
          s = '0;
          for (int l = 0; l < nl; l++)
            s = s | (VLEN'(gen((base + l) % items, w)) << (l*w));
          for (int pk = 0; pk < 3; pk++) begin
            o = {$urandom, $urandom, $urandom, $urandom};
            if (pk == 0)      p = '1;
            else if (pk == 1) p = PW'({$urandom, $urandom});
            else begin
              p = '1;
              for (int l = 0; l < nl; l++) if ((l + base) % 2 == 0) p[l*(w/8)] = 1'b0;
            end
            apply(sz, 1'(zm), s, o, p);
            check_vec(w, 1'(zm), s, o, p);
          end
        end
        // all lanes inactive, other bytes set
        o = {$urandom, $urandom, $urandom, $urandom};
        p = '1;
        for (int l = 0; l < nl; l++) p[l*(w/8)] = 1'b0;
        apply(sz, 1'(zm), s, o, p);
        check_vec(w, 1'(zm), s, o, p);
      end
    end

    // illegal size
    o = {$urandom, $urandom, $urandom, $urandom};
    apply(2'b00, 1'b1, s, o, '1);
    check("R9 illegal flag set", 64'(bad_size), 64'd1);
    check("R9 destination unchanged", 64'(result == o), 64'd1);

    // idle hold
    @(negedge clk);
    src_vec = ~src_vec; old_dst = ~old_dst; size_sel = 2'b01;
    @(negedge clk);
    check("R10 idle out_valid low", 64'(out_valid), 64'd0);
    check("R10 idle result held", 64'(result == o), 64'd1);
    check("R10 idle flag held", 64'(bad_size), 64'd1);

    // legal request clears flag
    apply(2'b10, 1'b0, '0, o, '1);
    check("R9 flag cleared", 64'(bad_size), 64'd0);
    check("R5 zero word lane0", 64'(result[31:0]), 64'h80000000);

    done = 1;
    summary();
  end
endmodule